// File: doc/BRIEF.md
# Page-offset-indexed, frame-tagged cache lookup unit

This block is the read-side lookup path of a four-way set-associative data cache. When a load is accepted, the set is chosen from address bits that lie inside the 4 KiB page offset. Those bits are the same before and after translation, so the tag/data arrays can be read in the same cycle that an eight-entry fully associative translation buffer turns the virtual page number into a physical frame number. One cycle later, the frame number plus any spare page-offset bits above the set index form the physical tag. This tag is compared against the stored tags of every way to produce the hit flag, the way and the selected data word.

When the translation buffer has no entry for the page, the unit raises a fault and parks the request. It resumes by itself once the buffer write port installs a mapping. When the translation is valid but no way matches, the unit asks for a refill with the physical line address. It then writes the returned line into the way chosen by a per-set tree pseudo-LRU, and answers the load from that line. The cache contents do not depend on the address space. Flushing the translation buffer leaves every line in place, and different virtual pages that alias one frame share one line.

Top module: `vipt_cache`

## Requirements
- R1: After reset, req_ready is 1 and rsp_valid, refill_req and xlat_fault are 0. Every cache line is invalid, so the first access to any set misses.
- R2: A request whose page is mapped and whose line is present gets rsp_valid=1 and rsp_hit=1 in the cycle after acceptance. rsp_data is the 32-bit word at bits [32*s+31:32*s] of the 128-bit line, where s = vaddr[3:2].
- R3: req_ready is 1 only while no request is in flight. It drops in the cycle after a request is accepted and stays low until the response.
- R4: A request whose virtual page has no valid buffer entry raises xlat_fault from the second cycle after acceptance. xlat_fault stays high with no response and no refill request until a buffer write maps the page. The lookup then resumes and completes normally.
- R5: A translated request that misses raises refill_req with refill_paddr = {frame number, vaddr[11:4], 4'b0000}. Both are held until refill_valid.
- R6: In the cycle refill_valid is high during a refill request, the unit answers with rsp_valid=1, rsp_hit=0 and the addressed word of refill_line. The line is installed, so a repeated access hits.
- R7: A hit needs the stored physical tag to equal the translated frame. Two pages with the same offset but different frames occupy different ways.
- R8: Two virtual pages mapped to the same frame hit the same line in the same way, with no second copy.
- R9: Flushing the translation buffer does not invalidate cache lines. After a mapping is reinstalled, previously filled lines still hit.
- R10: After tlb_flush, every page faults until it is written again.
- R11: Successive refills into one set, starting from reset, choose ways 0, 2, 1, 3, then 0 again (3-bit tree pseudo-LRU).
- R12: A hit marks its way most recently used, so the next refill in that set avoids it.
- R13: Buffer writes fill its 8 entries in round-robin order starting at entry 0 after reset or flush. The ninth write replaces the first mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load request present |
| req_vaddr | input | 32 | Virtual byte address of the load |
| req_ready | output | 1 | Unit idle, request accepted this cycle |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Response came from a resident line |
| rsp_way | output | 2 | Way that holds the line |
| rsp_data | output | 32 | Loaded word |
| xlat_fault | output | 1 | Pending request has no translation |
| refill_req | output | 1 | Line fetch requested |
| refill_paddr | output | 32 | Physical line address of the fetch |
| refill_valid | input | 1 | Fetched line present |
| refill_line | input | 128 | Fetched line data |
| tlb_wr_en | input | 1 | Install a translation |
| tlb_wr_vpn | input | 20 | Virtual page number to install |
| tlb_wr_pfn | input | 20 | Physical frame number to install |
| tlb_flush | input | 1 | Drop all translations |

## Verification
The properties assume that the translation buffer never holds two live entries for one virtual page. Without that, the one-entry-matches check would not hold. The bench keeps to this by installing only pages that are absent, or that have just been overwritten, at the time of the write. The fault-hold property also assumes that no buffer write or flush arrives in the one cycle between a lookup that misses translation and the fault state. The bench issues buffer writes only after xlat_fault is already visible, or while the unit is idle. Refill data is presented only while refill_req is high, and a new request is raised only after the previous response has been seen.

// File: rtl/vipt_pkg.sv
package vipt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOOK  = 2'd1,
    ST_FAULT = 2'd2,
    ST_MISS  = 2'd3
  } lk_state_e;

  // Tree bits: [0] root (0 = left pair older), [1] left pair, [2] right pair.
  function automatic logic [1:0] plru_victim(input logic [2:0] t);
    if (!t[0]) return t[1] ? 2'd1 : 2'd0;
    else       return t[2] ? 2'd3 : 2'd2;
  endfunction

  // Point every node on the path away from the way just used.
  function automatic logic [2:0] plru_touch(input logic [2:0] t, input logic [1:0] w);
    logic [2:0] n;
    n = t;
    n[0] = ~w[1];
    if (!w[1]) n[1] = ~w[0];
    else       n[2] = ~w[0];
    return n;
  endfunction

endpackage

// File: rtl/vipt_tlb.sv
module vipt_tlb #(
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int ENTRIES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               wr_en,
  input  logic [VPN_W-1:0]   wr_vpn,
  input  logic [PFN_W-1:0]   wr_pfn,
  input  logic [VPN_W-1:0]   lk_vpn,
  output logic [ENTRIES-1:0] lk_hit_vec,
  output logic               lk_hit,
  output logic [PFN_W-1:0]   lk_pfn
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] ent_valid;
  logic [VPN_W-1:0]   ent_vpn [ENTRIES];
  logic [PFN_W-1:0]   ent_pfn [ENTRIES];
  logic [PTR_W-1:0]   rr_ptr;
  logic [PTR_W-1:0]   wr_slot;

  assign wr_slot = flush ? '0 : rr_ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_valid <= '0;
      rr_ptr    <= '0;
    end else begin
      if (flush) begin
        ent_valid <= '0;
        rr_ptr    <= '0;
      end
      if (wr_en) begin
        ent_valid[wr_slot] <= 1'b1;
        rr_ptr <= (wr_slot == PTR_W'(ENTRIES-1)) ? '0 : wr_slot + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      ent_vpn[wr_slot] <= wr_vpn;
      ent_pfn[wr_slot] <= wr_pfn;
    end
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_match
    assign lk_hit_vec[e] = ent_valid[e] && (ent_vpn[e] == lk_vpn);
  end

  assign lk_hit = |lk_hit_vec;

  always_comb begin
    lk_pfn = '0;
    for (int e = 0; e < ENTRIES; e++)
      if (lk_hit_vec[e]) lk_pfn = lk_pfn | ent_pfn[e];
  end

endmodule

// File: rtl/vipt_ways.sv
module vipt_ways #(
  parameter int WAYS   = 4,
  parameter int SETS   = 256,
  parameter int TAG_W  = 20,
  parameter int LINE_W = 128,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rd_en,
  input  logic [IDX_W-1:0]             rd_idx,
  output logic [WAYS-1:0]              rd_valid,
  output logic [WAYS-1:0][TAG_W-1:0]   rd_tag,
  output logic [WAYS-1:0][LINE_W-1:0]  rd_line,
  input  logic                         wr_en,
  input  logic [WAY_W-1:0]             wr_way,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [TAG_W-1:0]             wr_tag,
  input  logic [LINE_W-1:0]            wr_line
);

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [SETS-1:0]   line_vld;
    logic [TAG_W-1:0]  tag_mem  [SETS];
    logic [LINE_W-1:0] line_mem [SETS];
    logic              vld_q;
    logic [TAG_W-1:0]  tag_q;
    logic [LINE_W-1:0] line_q;
    logic              sel;

    assign sel = wr_en && (wr_way == WAY_W'(w));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        line_vld <= '0;
        vld_q    <= 1'b0;
      end else begin
        if (sel) line_vld[wr_idx] <= 1'b1;
        if (rd_en) vld_q <= line_vld[rd_idx];
      end
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        tag_mem[wr_idx]  <= wr_tag;
        line_mem[wr_idx] <= wr_line;
      end
      if (rd_en) begin
        tag_q  <= tag_mem[rd_idx];
        line_q <= line_mem[rd_idx];
      end
    end

    assign rd_valid[w] = vld_q;
    assign rd_tag[w]   = tag_q;
    assign rd_line[w]  = line_q;
  end

endmodule

// File: rtl/vipt_plru.sv
module vipt_plru #(
  parameter int SETS = 256,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  output logic [1:0]       victim,
  input  logic             upd_en,
  input  logic [1:0]       upd_way
);
  import vipt_pkg::*;

  logic [2:0] tree [SETS];

  assign victim = plru_victim(tree[idx]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) tree[s] <= 3'b000;
    end else if (upd_en) begin
      tree[idx] <= plru_touch(tree[idx], upd_way);
    end
  end

endmodule

// File: rtl/vipt_cache.sv
module vipt_cache #(
  parameter int VA_W        = 32,
  parameter int PA_W        = 32,
  parameter int PAGE_BITS   = 12,
  parameter int LINE_BYTES  = 16,
  parameter int SETS        = 256,
  parameter int WAYS        = 4,
  parameter int TLB_ENTRIES = 8,
  parameter int WORD_W      = 32,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int IDX_W  = $clog2(SETS),
  localparam int VPN_W  = VA_W - PAGE_BITS,
  localparam int PFN_W  = PA_W - PAGE_BITS,
  localparam int TAG_W  = PA_W - OFF_W - IDX_W,
  localparam int LINE_W = LINE_BYTES * 8,
  localparam int BYTE_W = $clog2(WORD_W / 8),
  localparam int WSEL_W = OFF_W - BYTE_W,
  localparam int WAY_W  = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [WAY_W-1:0]  rsp_way,
  output logic [WORD_W-1:0] rsp_data,
  output logic              xlat_fault,
  output logic              refill_req,
  output logic [PA_W-1:0]   refill_paddr,
  input  logic              refill_valid,
  input  logic [LINE_W-1:0] refill_line,
  input  logic              tlb_wr_en,
  input  logic [VPN_W-1:0]  tlb_wr_vpn,
  input  logic [PFN_W-1:0]  tlb_wr_pfn,
  input  logic              tlb_flush
);
  import vipt_pkg::*;

  lk_state_e state, state_nx;

  logic [VA_W-1:0]  vaddr_q;
  logic             xlat_ok_q;
  logic [PFN_W-1:0] pfn_q;

  // Named internal events, used by the checker.
  logic                    accept;
  logic                    fault_retry;
  logic                    lookup_hit;
  logic                    refill_done;
  logic [TLB_ENTRIES-1:0]  tlb_hit_vec;
  logic [WAYS-1:0]         way_hit_vec;

  logic [VPN_W-1:0]  lk_vpn;
  logic              lk_hit;
  logic [PFN_W-1:0]  lk_pfn;
  logic              rd_en;
  logic [IDX_W-1:0]  rd_idx;
  logic [IDX_W-1:0]  cur_idx;
  logic [WSEL_W-1:0] cur_wsel;
  logic [PA_W-1:0]   paddr_q;
  logic [TAG_W-1:0]  tag_q;
  logic [WAY_W-1:0]  hit_way;
  logic [1:0]        victim;

  logic [WAYS-1:0]              arr_valid;
  logic [WAYS-1:0][TAG_W-1:0]   arr_tag;
  logic [WAYS-1:0][LINE_W-1:0]  arr_line;

  // Index and word select come only from page-offset bits.
  assign cur_idx  = vaddr_q[OFF_W +: IDX_W];
  assign cur_wsel = vaddr_q[BYTE_W +: WSEL_W];

  assign accept      = req_valid && (state == ST_IDLE);
  assign lk_vpn      = (state == ST_IDLE) ? req_vaddr[VA_W-1:PAGE_BITS] : vaddr_q[VA_W-1:PAGE_BITS];
  assign fault_retry = (state == ST_FAULT) && lk_hit;
  assign rd_en       = accept || fault_retry;
  assign rd_idx      = (state == ST_IDLE) ? req_vaddr[OFF_W +: IDX_W] : cur_idx;

  vipt_tlb #(.VPN_W(VPN_W), .PFN_W(PFN_W), .ENTRIES(TLB_ENTRIES)) u_tlb (
    .clk(clk), .rst_n(rst_n), .flush(tlb_flush),
    .wr_en(tlb_wr_en), .wr_vpn(tlb_wr_vpn), .wr_pfn(tlb_wr_pfn),
    .lk_vpn(lk_vpn), .lk_hit_vec(tlb_hit_vec), .lk_hit(lk_hit), .lk_pfn(lk_pfn)
  );

  vipt_ways #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_ways (
    .clk(clk), .rst_n(rst_n),
    .rd_en(rd_en), .rd_idx(rd_idx),
    .rd_valid(arr_valid), .rd_tag(arr_tag), .rd_line(arr_line),
    .wr_en(refill_done), .wr_way(WAY_W'(victim)), .wr_idx(cur_idx),
    .wr_tag(tag_q), .wr_line(refill_line)
  );

  vipt_plru #(.SETS(SETS)) u_plru (
    .clk(clk), .rst_n(rst_n), .idx(cur_idx), .victim(victim),
    .upd_en(lookup_hit || refill_done),
    .upd_way(lookup_hit ? 2'(hit_way) : victim)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      xlat_ok_q <= 1'b0;
    end else begin
      state <= state_nx;
      if (rd_en) xlat_ok_q <= lk_hit;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) vaddr_q <= req_vaddr;
    if (rd_en)  pfn_q   <= lk_pfn;
  end

  // Physical tag: frame number plus any page-offset bits above the index.
  assign paddr_q = {pfn_q, vaddr_q[PAGE_BITS-1:0]};
  assign tag_q   = paddr_q[PA_W-1:OFF_W+IDX_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign way_hit_vec[w] = arr_valid[w] && (arr_tag[w] == tag_q);
  end

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (way_hit_vec[w]) hit_way = WAY_W'(w);
  end

  assign lookup_hit  = (state == ST_LOOK) && xlat_ok_q && (|way_hit_vec);
  assign refill_done = (state == ST_MISS) && refill_valid;

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE:  if (accept) state_nx = ST_LOOK;
      ST_LOOK:  if (!xlat_ok_q)  state_nx = ST_FAULT;
                else if (lookup_hit) state_nx = ST_IDLE;
                else state_nx = ST_MISS;
      ST_FAULT: if (lk_hit) state_nx = ST_LOOK;
      ST_MISS:  if (refill_valid) state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  assign req_ready    = (state == ST_IDLE);
  assign xlat_fault   = (state == ST_FAULT);
  assign refill_req   = (state == ST_MISS);
  assign refill_paddr = {paddr_q[PA_W-1:OFF_W], {OFF_W{1'b0}}};

  assign rsp_valid = lookup_hit || refill_done;
  assign rsp_hit   = lookup_hit;
  assign rsp_way   = lookup_hit ? hit_way : WAY_W'(victim);
  assign rsp_data  = lookup_hit ? arr_line[hit_way][cur_wsel*WORD_W +: WORD_W]
                                : refill_line[cur_wsel*WORD_W +: WORD_W];

endmodule

// File: rtl/vipt_cache_checker.sv
module vipt_cache_checker #(
  parameter int WAYS        = 4,
  parameter int TLB_ENTRIES = 8,
  parameter int PA_W        = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic                   req_ready,
  input logic                   rsp_valid,
  input logic                   rsp_hit,
  input logic                   xlat_fault,
  input logic                   refill_req,
  input logic                   refill_valid,
  input logic [PA_W-1:0]        refill_paddr,
  input logic                   tlb_wr_en,
  input logic                   fault_retry,
  input logic [TLB_ENTRIES-1:0] tlb_hit_vec,
  input logic [WAYS-1:0]        way_hit_vec
);

  p_busy_after_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  p_rsp_while_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  p_fault_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xlat_fault |-> !rsp_valid && !refill_req);

  p_fault_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xlat_fault && !fault_retry && !tlb_wr_en |=> xlat_fault);

  p_refill_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    refill_req && !refill_valid |=> refill_req && $stable(refill_paddr));

  p_refill_answers_r6: assert property (@(posedge clk) disable iff (!rst_n)
    refill_req && refill_valid |-> rsp_valid && !rsp_hit);

  p_single_way_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(way_hit_vec));

  p_single_entry_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tlb_hit_vec));

endmodule

bind vipt_cache vipt_cache_checker #(
  .WAYS(WAYS), .TLB_ENTRIES(TLB_ENTRIES), .PA_W(PA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .xlat_fault(xlat_fault),
  .refill_req(refill_req), .refill_valid(refill_valid), .refill_paddr(refill_paddr),
  .tlb_wr_en(tlb_wr_en), .fault_retry(fault_retry),
  .tlb_hit_vec(tlb_hit_vec), .way_hit_vec(way_hit_vec)
);

// File: tb/vipt_cache_bench.sv
module vipt_cache_bench;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid;
  logic [31:0]  req_vaddr;
  logic         req_ready;
  logic         rsp_valid;
  logic         rsp_hit;
  logic [1:0]   rsp_way;
  logic [31:0]  rsp_data;
  logic         xlat_fault;
  logic         refill_req;
  logic [31:0]  refill_paddr;
  logic         refill_valid;
  logic [127:0] refill_line;
  logic         tlb_wr_en;
  logic [19:0]  tlb_wr_vpn;
  logic [19:0]  tlb_wr_pfn;
  logic         tlb_flush;

  always #4 clk = ~clk;

  vipt_cache u_vipt_cache (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_way(rsp_way), .rsp_data(rsp_data), .xlat_fault(xlat_fault),
    .refill_req(refill_req), .refill_paddr(refill_paddr),
    .refill_valid(refill_valid), .refill_line(refill_line),
    .tlb_wr_en(tlb_wr_en), .tlb_wr_vpn(tlb_wr_vpn), .tlb_wr_pfn(tlb_wr_pfn),
    .tlb_flush(tlb_flush)
  );

  int total = 0;
  int bad   = 0;

  // Vector table: virtual address, expected hit, expected way, expected frame.
  localparam int NV = 13;
  localparam logic [31:0] V_VA [NV] = '{
    32'h000100A4, 32'h000100A8, 32'h000120A4, 32'h000110A4, 32'h000130AC,
    32'h000140A0, 32'h000100A4, 32'h000150A4, 32'h000110A4, 32'h000100A4,
    32'h000103F0, 32'h000153F4, 32'h000103F0 };
  localparam bit V_HIT [NV] = '{0, 1, 1, 0, 0, 0, 1, 0, 0, 1, 0, 0, 1};
  localparam logic [1:0] V_WAY [NV] = '{0, 0, 0, 2, 1, 3, 0, 2, 1, 0, 0, 2, 0};
  localparam logic [19:0] V_PFN [NV] = '{
    20'h200, 20'h200, 20'h200, 20'h300, 20'h400, 20'h500, 20'h200,
    20'h600, 20'h300, 20'h200, 20'h200, 20'h600, 20'h200 };

  // Result of the last wait: 0 hit, 1 refilled, 2 fault, 3 nothing.
  int          got_kind;
  logic [1:0]  got_way;
  logic [31:0] got_data;
  int          got_lat;

  function automatic logic [31:0] mk_word(input logic [31:0] pa_line, input int k);
    return pa_line ^ (32'h5A00_0000 + 32'(k));
  endfunction

  function automatic logic [127:0] mk_line(input logic [31:0] pa_line);
    logic [127:0] l;
    for (int k = 0; k < 4; k++) l[k*32 +: 32] = mk_word(pa_line, k);
    return l;
  endfunction

  function automatic logic [31:0] line_pa(input logic [19:0] pfn, input logic [31:0] va);
    return {pfn, va[11:4], 4'h0};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tlb_write(input logic [19:0] vpn, input logic [19:0] pfn);
    @(negedge clk);
    tlb_wr_en = 1'b1; tlb_wr_vpn = vpn; tlb_wr_pfn = pfn;
    @(posedge clk);
    @(negedge clk);
    tlb_wr_en = 1'b0;
  endtask

  task automatic flush_tlb();
    @(negedge clk);
    tlb_flush = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tlb_flush = 1'b0;
  endtask

  task automatic issue(input logic [31:0] va);
    @(negedge clk);
    chk(req_ready == 1'b1, "R3", "ready before accept", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_vaddr = va;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R3", "ready after accept", 32'(req_ready), 32'd0);
  endtask

  // Starts at a negedge one cycle after acceptance (or after a fault clears).
  task automatic wait_result(input logic [31:0] exp_pa);
    bit done = 0;
    int n = 0;
    got_kind = 3;
    got_lat  = 1;
    while (!done && n < 20) begin
      if (rsp_valid) begin
        got_kind = rsp_hit ? 0 : 1; got_way = rsp_way; got_data = rsp_data;
        done = 1;
      end else if (xlat_fault) begin
        got_kind = 2; done = 1;
      end else if (refill_req) begin
        chk(refill_paddr == exp_pa, "R5", "refill address", refill_paddr, exp_pa);
        refill_valid = 1'b1;
        refill_line  = mk_line(exp_pa);
        #1;
        chk(rsp_valid && !rsp_hit, "R6", "refill response", {30'd0, rsp_valid, rsp_hit}, 32'd2);
        got_kind = 1; got_way = rsp_way; got_data = rsp_data;
        @(posedge clk);
        @(negedge clk);
        refill_valid = 1'b0;
        done = 1;
      end else begin
        @(posedge clk);
        @(negedge clk);
        got_lat++;
        n++;
      end
    end
  endtask

  task automatic fault_hold(input string req);
    for (int c = 0; c < 3; c++) begin
      chk(xlat_fault && !rsp_valid && !refill_req, req, "fault held quiet",
          {29'd0, xlat_fault, rsp_valid, refill_req}, 32'd4);
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // Install a mapping while a request is parked, then collect the response.
  task automatic resolve(input logic [19:0] vpn, input logic [19:0] pfn, input logic [31:0] va);
    tlb_write(vpn, pfn);
    @(posedge clk);
    @(negedge clk);
    wait_result(line_pa(pfn, va));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog run did not end");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; refill_valid = 1'b0;
    refill_line = '0; tlb_wr_en = 1'b0; tlb_wr_vpn = '0; tlb_wr_pfn = '0;
    tlb_flush = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "reset ready", 32'(req_ready), 32'd1);
    chk(!rsp_valid && !refill_req && !xlat_fault, "R1", "reset outputs idle",
        {29'd0, rsp_valid, refill_req, xlat_fault}, 32'd0);

    tlb_write(20'h10, 20'h200);
    tlb_write(20'h11, 20'h300);
    tlb_write(20'h12, 20'h200);
    tlb_write(20'h13, 20'h400);
    tlb_write(20'h14, 20'h500);
    tlb_write(20'h15, 20'h600);

    // Table walk: R1 first miss, R2 hit and word select, R7 frame compare,
    // R8 alias, R11 victim order, R12 hit protection.
    for (int i = 0; i < NV; i++) begin
      logic [31:0] pa;
      pa = line_pa(V_PFN[i], V_VA[i]);
      issue(V_VA[i]);
      wait_result(pa);
      chk(got_kind == (V_HIT[i] ? 0 : 1), V_HIT[i] ? "R2" : "R11", "hit or refill",
          32'(got_kind), V_HIT[i] ? 32'd0 : 32'd1);
      chk(got_way == V_WAY[i], V_HIT[i] ? "R8" : "R12", "way", 32'(got_way), 32'(V_WAY[i]));
      chk(got_data == mk_word(pa, int'(V_VA[i][3:2])), "R2", "data word",
          got_data, mk_word(pa, int'(V_VA[i][3:2])));
      if (V_HIT[i]) chk(got_lat == 1, "R2", "hit latency", 32'(got_lat), 32'd1);
    end

    // R4: unmapped page parks with a fault, then resumes after a write.
    issue(32'h000200A4);
    wait_result(32'h0);
    chk(got_kind == 2, "R4", "fault raised", 32'(got_kind), 32'd2);
    chk(got_lat == 2, "R4", "fault timing", 32'(got_lat), 32'd2);
    fault_hold("R4");
    resolve(20'h20, 20'h200, 32'h000200A4);
    chk(got_kind == 0 && got_way == 2'd0, "R4", "resume hits aliased line",
        {got_kind[29:0], got_way}, 32'd0);

    // R10: flush drops translations; R9: lines survive.
    flush_tlb();
    issue(32'h000100A4);
    wait_result(32'h0);
    chk(got_kind == 2, "R10", "fault after flush", 32'(got_kind), 32'd2);
    resolve(20'h10, 20'h200, 32'h000100A4);
    chk(got_kind == 0, "R9", "line kept across flush", 32'(got_kind), 32'd0);
    chk(got_data == mk_word(32'h002000A0, 1), "R9", "data kept", got_data,
        mk_word(32'h002000A0, 1));

    // R13: nine writes after a flush; the ninth replaces the first.
    flush_tlb();
    for (int e = 0; e < 9; e++) tlb_write(20'h30 + 20'(e), 20'h200);
    issue(32'h000300A4);
    wait_result(32'h0);
    chk(got_kind == 2, "R13", "first mapping replaced", 32'(got_kind), 32'd2);
    resolve(20'h30, 20'h200, 32'h000300A4);
    chk(got_kind == 0, "R13", "reinstalled page hits", 32'(got_kind), 32'd0);
    issue(32'h000380A4);
    wait_result(32'h0);
    chk(got_kind == 0, "R13", "ninth mapping live", 32'(got_kind), 32'd0);

    // R6: a refilled line in a fresh set hits on repeat.
    issue(32'h000387F8);
    wait_result(line_pa(20'h200, 32'h000387F8));
    chk(got_kind == 1 && got_way == 2'd0, "R6", "fresh set refill way0",
        {got_kind[29:0], got_way}, 32'd4);
    issue(32'h000387F8);
    wait_result(32'h0);
    chk(got_kind == 0 && got_data == mk_word(32'h002007F0, 2), "R6", "repeat hits",
        got_data, mk_word(32'h002007F0, 2));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule